// File: doc/BRIEF.md
# Chip-Select Bus Cycle Controller

This block runs the external memory cycles for one chip-select region. It takes one processor request at a time, of byte, word, longword or 16-byte line size. It breaks the request into beats that fit the region's data port, or runs a read burst, and drives the chip select, the beat address, the active-high byte strobes and the data lanes. A beat ends when either an internal wait-state countdown expires or the external system raises its transfer acknowledge.

The region settings are sampled when a request is accepted and held until the transfer completes:
- the first-beat wait count;
- the later-beat read wait code;
- auto-acknowledge;
- port width;
- whether strobes are also driven on reads;
- whether wide reads may burst.

Read data from successive beats is packed big-endian and returned right-aligned, with a one-cycle done pulse. Requests must be aligned to their size.

Top module: `cs_bus_ctrl`

## Requirements
- R1: With auto-acknowledge set and no external acknowledge, a beat that uses the initial wait count N (0..15) lasts N+1 cycles, with `bus_tack_o` high in its last cycle.
- R2: With auto-acknowledge clear, no beat ends until `bus_ta_i` is high; the beat ends in that same cycle, whatever the wait count.
- R3: `bus_ta_i` high during a beat ends that beat in the same cycle, even before the countdown expires.
- R4: In a burst read, beats after the first use the secondary code: 00 means use the initial count, and 01, 10 and 11 mean 0, 1 and 2 waits; the first beat always uses the initial count.
- R5: Port code 00 is 32-bit on bus bits 31:0, 01 is 8-bit on bits 31:24, and 10 or 11 is 16-bit on bits 31:16. Write data is driven only on those lanes, with the other lanes at zero, and read data is taken only from them. Strobe bit k covers bus bits 8k+7:8k.
- R6: On writes the strobes of the active lanes are always asserted. On reads they are asserted only when the strobe-on-read setting is 1 and are otherwise all zero.
- R7: With burst enable clear, a read wider than the port runs as size/port separate beats, each using the initial wait count, with `bus_burst_o` low.
- R8: With burst enable set, a read wider than the port runs as a burst with `bus_burst_o` high. The address rises by the port width in bytes between beats, so a line takes 4, 8 or 16 beats on a 32-, 16- or 8-bit port.
- R9: Writes never burst. A write wider than the port is split into port-sized beats, each using the initial wait count.
- R10: Read bytes are packed big-endian, with the first beat in the most significant positions, and returned right-aligned in `rdata_o`. `done_o` is a single-cycle pulse in the cycle after the final beat ends.
- R11: An access no wider than the port takes a single beat on the lanes selected by the low address bits, where byte offset 0 is bus bits 31:24.
- R12: While in reset and after it, `bus_cs_o` and `done_o` are low and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_iws_i | input | 4 | Initial wait count |
| cfg_srws_i | input | 2 | Later-beat burst read wait code |
| cfg_aa_i | input | 1 | Auto-acknowledge enable |
| cfg_ps_i | input | 2 | Port width code |
| cfg_bem_i | input | 1 | Assert strobes on reads too |
| cfg_bre_i | input | 1 | Allow burst reads |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, request accepted when valid |
| req_write_i | input | 1 | 1 = write |
| req_size_i | input | 2 | 00 byte, 01 word, 10 longword, 11 line |
| req_addr_i | input | ADDR_W | Byte address, size-aligned |
| req_wdata_i | input | 8*LINE_BYTES | Write data, right-aligned, big-endian |
| done_o | output | 1 | Transfer complete pulse |
| rdata_o | output | 8*LINE_BYTES | Read data, right-aligned, big-endian |
| bus_cs_o | output | 1 | Chip select |
| bus_we_o | output | 1 | Write cycle |
| bus_burst_o | output | 1 | Current beat is part of a burst |
| bus_addr_o | output | ADDR_W | Beat address |
| bus_be_o | output | 4 | Byte strobes |
| bus_dout_o | output | 32 | Write data lanes |
| bus_din_i | input | 32 | Read data lanes |
| bus_ta_i | input | 1 | External transfer acknowledge |
| bus_tack_o | output | 1 | Current beat terminates this cycle |

## Verification
The bench issues reads that fit the port, reads that are split, reads that burst on 8- and 16-bit ports, and writes wider than the port. Comparing beat counts and per-beat lengths separates split from burst handling and the initial wait count from the secondary one. The read data model puts filler on unused lanes, so a wrong lane choice or a reversed packing order shows up in the returned word. External acknowledges are raised both with auto-acknowledge clear and ahead of a long countdown, to show that the beat ends in exactly that cycle.

// File: rtl/cs_bus_pkg.sv
package cs_bus_pkg;
  localparam int BUS_BYTES = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_LINE = 2'b11
  } xfer_size_e;

  typedef struct packed {
    logic [3:0] iws;
    logic [1:0] srws;
    logic       aa;
    logic [1:0] ps;
    logic       bem;
    logic       bre;
  } cs_cfg_t;
endpackage

// File: rtl/cs_beat_plan.sv
module cs_beat_plan
  import cs_bus_pkg::*;
#(
  parameter int LINE_BYTES = 16,
  localparam int CNT_W = $clog2(LINE_BYTES) + 1
) (
  input  xfer_size_e       size_i,
  input  logic             write_i,
  input  logic [1:0]       ps_i,
  input  logic             bre_i,
  input  logic [1:0]       addr_lo_i,
  output logic [CNT_W-1:0] total_o,
  output logic [CNT_W-1:0] beats_o,
  output logic [2:0]       nb_o,
  output logic [1:0]       off_o,
  output logic             burst_o
);
  logic [2:0] pb;
  logic [1:0] psh;
  logic       wide;

  always_comb begin
    case (size_i)
      SZ_BYTE: total_o = CNT_W'(1);
      SZ_WORD: total_o = CNT_W'(2);
      SZ_LONG: total_o = CNT_W'(4);
      default: total_o = CNT_W'(LINE_BYTES);
    endcase
    case (ps_i)
      2'b00:   begin pb = 3'd4; psh = 2'd2; end
      2'b01:   begin pb = 3'd1; psh = 2'd0; end
      default: begin pb = 3'd2; psh = 2'd1; end
    endcase
    wide = total_o > CNT_W'(pb);
    if (wide) begin
      beats_o = total_o >> psh;
      nb_o    = pb;
      off_o   = 2'd0;
    end else begin
      beats_o = CNT_W'(1);
      nb_o    = total_o[2:0];
      case (ps_i)
        2'b00:   off_o = addr_lo_i;
        2'b01:   off_o = 2'd0;
        default: off_o = {1'b0, addr_lo_i[0]};
      endcase
    end
    burst_o = !write_i && bre_i && wide;
  end
endmodule

// File: rtl/cs_wait_timer.sv
module cs_wait_timer #(
  parameter int WS_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            aa_i,
  input  logic            ta_i,
  input  logic [WS_W-1:0] limit_i,
  output logic            tack_o
);
  logic [WS_W-1:0] cnt_q;

  assign tack_o = run_i && (ta_i || (aa_i && cnt_q == limit_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tack_o)  cnt_q <= '0;
    else if (cnt_q != '1)       cnt_q <= cnt_q + 1'b1;
  end

  AST_WAIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && aa_i |-> cnt_q <= limit_i); // R1
  AST_NO_INT_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !aa_i && !ta_i |-> !tack_o); // R2
  AST_EXT_ACK_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && ta_i |-> tack_o); // R3
endmodule

// File: rtl/cs_lane_mux.sv
module cs_lane_mux
  import cs_bus_pkg::*;
(
  input  logic [2:0]  nb_i,
  input  logic [1:0]  off_i,
  input  logic [31:0] wchunk_i,
  input  logic [31:0] din_i,
  output logic [31:0] dout_o,
  output logic [3:0]  lanes_o,
  output logic [31:0] rchunk_o
);
  logic [2:0]  sh;
  logic [31:0] wpos;
  logic [31:0] dmask;

  // lowest occupied lane index; offset 0 sits on the top lane
  assign sh   = 3'd4 - nb_i - {1'b0, off_i};
  assign wpos = wchunk_i << {sh, 3'b000};

  for (genvar g = 0; g < BUS_BYTES; g++) begin : g_lane
    assign lanes_o[g]      = (3'(g) >= sh) && (3'(g) < sh + nb_i);
    assign dout_o[8*g+:8]  = lanes_o[g] ? wpos[8*g+:8] : 8'h00;
    assign dmask[8*g+:8]   = lanes_o[g] ? din_i[8*g+:8] : 8'h00;
  end

  assign rchunk_o = dmask >> {sh, 3'b000};
endmodule

// File: rtl/cs_bus_ctrl.sv
module cs_bus_ctrl
  import cs_bus_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  localparam int DW    = 8 * LINE_BYTES,
  localparam int CNT_W = $clog2(LINE_BYTES) + 1,
  localparam int WS_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        cfg_iws_i,
  input  logic [1:0]        cfg_srws_i,
  input  logic              cfg_aa_i,
  input  logic [1:0]        cfg_ps_i,
  input  logic              cfg_bem_i,
  input  logic              cfg_bre_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [1:0]        req_size_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              done_o,
  output logic [DW-1:0]     rdata_o,
  output logic              bus_cs_o,
  output logic              bus_we_o,
  output logic              bus_burst_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [3:0]        bus_be_o,
  output logic [31:0]       bus_dout_o,
  input  logic [31:0]       bus_din_i,
  input  logic              bus_ta_i,
  output logic              bus_tack_o
);
  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  state_e            state_q;
  cs_cfg_t           cfg_q;
  logic              we_q, first_q, burst_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic [2:0]        nb_q;
  logic [1:0]        off_q;
  logic [DW-1:0]     wsh_q, acc_q, rdata_q;

  logic [CNT_W-1:0]  p_total, p_beats;
  logic [2:0]        p_nb;
  logic [1:0]        p_off;
  logic              p_burst;
  logic [CNT_W-1:0]  lead;
  logic              accept, run, tack;
  logic [WS_W-1:0]   limit;
  logic [31:0]       wchunk, lane_dout, rchunk;
  logic [3:0]        lanes;
  logic [DW-1:0]     acc_nx;

  cs_beat_plan #(.LINE_BYTES(LINE_BYTES)) u_plan (
    .size_i   (xfer_size_e'(req_size_i)),
    .write_i  (req_write_i),
    .ps_i     (cfg_ps_i),
    .bre_i    (cfg_bre_i),
    .addr_lo_i(req_addr_i[1:0]),
    .total_o  (p_total),
    .beats_o  (p_beats),
    .nb_o     (p_nb),
    .off_o    (p_off),
    .burst_o  (p_burst)
  );

  assign run    = (state_q == ST_RUN);
  assign accept = req_valid_i && !run;
  assign lead   = CNT_W'(LINE_BYTES) - p_total;

  // later burst beats take the secondary count when it is enabled
  assign limit = (burst_q && !first_q && cfg_q.srws != 2'b00)
               ? WS_W'(cfg_q.srws - 2'd1) : cfg_q.iws;

  cs_wait_timer #(.WS_W(WS_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .aa_i   (cfg_q.aa),
    .ta_i   (bus_ta_i),
    .limit_i(limit),
    .tack_o (tack)
  );

  assign wchunk = wsh_q[DW-1 -: 32] >> {3'd4 - nb_q, 3'b000};

  cs_lane_mux u_lanes (
    .nb_i    (nb_q),
    .off_i   (off_q),
    .wchunk_i(wchunk),
    .din_i   (bus_din_i),
    .dout_o  (lane_dout),
    .lanes_o (lanes),
    .rchunk_o(rchunk)
  );

  assign acc_nx = (acc_q << {nb_q, 3'b000}) | DW'(rchunk);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      we_q    <= 1'b0;
      first_q <= 1'b0;
      burst_q <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      left_q  <= '0;
      nb_q    <= '0;
      off_q   <= '0;
      wsh_q   <= '0;
      acc_q   <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q <= ST_RUN;
        cfg_q   <= '{iws: cfg_iws_i, srws: cfg_srws_i, aa: cfg_aa_i,
                     ps: cfg_ps_i, bem: cfg_bem_i, bre: cfg_bre_i};
        we_q    <= req_write_i;
        first_q <= 1'b1;
        burst_q <= p_burst;
        addr_q  <= req_addr_i;
        left_q  <= p_beats;
        nb_q    <= p_nb;
        off_q   <= p_off;
        wsh_q   <= req_wdata_i << {lead, 3'b000};
        acc_q   <= '0;
      end else if (tack) begin
        first_q <= 1'b0;
        addr_q  <= addr_q + ADDR_W'(nb_q);
        wsh_q   <= wsh_q << {nb_q, 3'b000};
        acc_q   <= acc_nx;
        left_q  <= left_q - 1'b1;
        if (left_q == CNT_W'(1)) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          if (!we_q) rdata_q <= acc_nx;
        end
      end
    end
  end

  assign req_ready_o = !run;
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;
  assign bus_cs_o    = run;
  assign bus_we_o    = run && we_q;
  assign bus_burst_o = run && burst_q;
  assign bus_addr_o  = addr_q;
  assign bus_be_o    = (run && (we_q || cfg_q.bem)) ? lanes : 4'b0000;
  assign bus_dout_o  = (run && we_q) ? lane_dout : 32'h0;
  assign bus_tack_o  = tack;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_READ_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cs_o && !bus_we_o && !cfg_q.bem |-> bus_be_o == 4'b0000); // R6
  AST_WRITE_NO_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |-> !bus_burst_o); // R9
  AST_BURST_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_burst_o |-> cfg_q.bre); // R8
  AST_NARROW_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cs_o && cfg_q.ps == 2'b01 |-> bus_be_o[2:0] == 3'b000); // R5
endmodule

// File: tb/tb_cs_bus_ctrl.sv
module tb_cs_bus_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] iws = '0;
  logic [1:0] srws = '0, ps = '0, size = '0;
  logic aa = 1'b1, bem = 1'b0, bre = 1'b0;
  logic valid = 1'b0, ready, wr = 1'b0, done;
  logic [AW-1:0] addr = '0, baddr_o;
  logic [DW-1:0] wdata = '0, rdata;
  logic cs, we, burst, tack, ta = 1'b0;
  logic [3:0] be;
  logic [31:0] dout, din = '0;

  int n_chk = 0, n_fail = 0;
  int nbeats;
  int blen[16];
  logic [31:0] b_addr[16], b_dout[16];
  logic [3:0] b_be[16];
  logic b_burst[16];
  logic [DW-1:0] rd_got;

  always #(CLK_PERIOD/2) clk = ~clk;

  cs_bus_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_iws_i(iws), .cfg_srws_i(srws), .cfg_aa_i(aa), .cfg_ps_i(ps),
    .cfg_bem_i(bem), .cfg_bre_i(bre),
    .req_valid_i(valid), .req_ready_o(ready), .req_write_i(wr),
    .req_size_i(size), .req_addr_i(addr), .req_wdata_i(wdata),
    .done_o(done), .rdata_o(rdata),
    .bus_cs_o(cs), .bus_we_o(we), .bus_burst_o(burst), .bus_addr_o(baddr_o),
    .bus_be_o(be), .bus_dout_o(dout), .bus_din_i(din), .bus_ta_i(ta),
    .bus_tack_o(tack)
  );

  function automatic logic [7:0] mb(input logic [31:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  function automatic logic [31:0] lanes_for(input logic [31:0] a);
    logic [31:0] b;
    case (ps)
      2'b00:   begin b = a & ~32'd3; return {mb(b), mb(b+1), mb(b+2), mb(b+3)}; end
      2'b01:   return {mb(a), 24'hEEEEEE};
      default: begin b = a & ~32'd1; return {mb(b), mb(b+1), 16'hEEEE}; end
    endcase
  endfunction

  function automatic logic [DW-1:0] exp_read(input logic [31:0] a, input int n);
    logic [DW-1:0] e = '0;
    for (int i = 0; i < n; i++) e = (e << 8) | DW'(mb(a + 32'(i)));
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [3:0] i, input logic [1:0] s, input logic a,
                         input logic [1:0] p, input logic m, input logic r);
    iws = i; srws = s; aa = a; ps = p; bem = m; bre = r;
  endtask

  task automatic run_xfer(input logic w, input logic [1:0] sz, input logic [31:0] a,
                          input logic [DW-1:0] wd, input int ta_at);
    int cyc = 0, guard = 0;
    bit seen = 0;
    @(negedge clk);
    valid = 1'b1; wr = w; size = sz; addr = a; wdata = wd;
    nbeats = 0;
    @(negedge clk);
    while (guard < 500) begin
      valid = 1'b0;
      if (done) begin seen = 1; break; end
      ta  = cs && ta_at >= 0 && cyc == ta_at;
      din = lanes_for(baddr_o);
      #1;
      if (cs && tack && nbeats < 16) begin
        blen[nbeats] = cyc + 1; b_addr[nbeats] = baddr_o; b_be[nbeats] = be;
        b_dout[nbeats] = dout; b_burst[nbeats] = burst;
        nbeats++; cyc = 0;
      end else if (cs) cyc++;
      guard++;
      @(negedge clk);
    end
    ta = 1'b0;
    chk(seen, "R10 done seen", DW'(seen), 1);
    rd_got = rdata;
    @(negedge clk);
    chk(!done && ready, "R10 done single pulse", DW'(done), 0);
  endtask

  task automatic t_reset;
    #1;
    chk(!cs && !done && ready, "R12 reset state", {cs, done, ready}, 3'b001);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(!cs && !done && ready, "R12 after reset", {cs, done, ready}, 3'b001);
  endtask

  task automatic t_long32_read;
    set_cfg(4'd2, 2'b00, 1'b1, 2'b00, 1'b0, 1'b0);
    run_xfer(1'b0, 2'b10, 32'h100, '0, -1);
    chk(nbeats == 1 && blen[0] == 3, "R1 beat length", blen[0], 3);
    chk(b_be[0] == 4'b0000, "R6 read strobes off", b_be[0], 0);
    chk(rd_got == exp_read(32'h100, 4), "R10 long read", rd_got, exp_read(32'h100, 4));
  endtask

  task automatic t_line8_burst;
    bit ok_len = 1, ok_addr = 1, ok_b = 1;
    set_cfg(4'd3, 2'b10, 1'b1, 2'b01, 1'b1, 1'b1);
    run_xfer(1'b0, 2'b11, 32'h40, '0, -1);
    chk(nbeats == 16, "R8 line on 8-bit port beats", nbeats, 16);
    for (int i = 0; i < 16; i++) begin
      if (blen[i] != (i == 0 ? 4 : 2)) ok_len = 0;
      if (b_addr[i] != 32'h40 + 32'(i)) ok_addr = 0;
      if (!b_burst[i] || b_be[i] != 4'b1000) ok_b = 0;
    end
    chk(ok_len, "R4 secondary one wait", blen[1], 2);
    chk(ok_addr, "R8 address increments", b_addr[1], 32'h41);
    chk(ok_b, "R8 burst flag and R6 read strobes", b_be[1], 4'b1000);
    chk(rd_got == exp_read(32'h40, 16), "R10 line packing", rd_got, exp_read(32'h40, 16));
  endtask

  task automatic t_srws_codes;
    set_cfg(4'd1, 2'b00, 1'b1, 2'b10, 1'b0, 1'b1);
    run_xfer(1'b0, 2'b10, 32'h80, '0, -1);
    chk(nbeats == 2 && blen[0] == 2 && blen[1] == 2, "R4 code 00 uses initial", blen[1], 2);
    chk(b_addr[1] == 32'h82 && b_burst[0], "R8 16-bit burst step", b_addr[1], 32'h82);
    chk(rd_got == exp_read(32'h80, 4), "R5 16-bit lanes sampled", rd_got, exp_read(32'h80, 4));
    set_cfg(4'd4, 2'b11, 1'b1, 2'b01, 1'b0, 1'b1);
    run_xfer(1'b0, 2'b01, 32'h90, '0, -1);
    chk(nbeats == 2 && blen[0] == 5 && blen[1] == 3, "R4 code 11 two waits", blen[1], 3);
  endtask

  task automatic t_split;
    bit ok = 1;
    set_cfg(4'd0, 2'b11, 1'b1, 2'b01, 1'b0, 1'b0);
    run_xfer(1'b0, 2'b10, 32'h10, '0, -1);
    for (int i = 0; i < 4; i++) if (blen[i] != 1 || b_burst[i]) ok = 0;
    chk(nbeats == 4 && ok, "R7 split read beats", nbeats, 4);
    chk(rd_got == exp_read(32'h10, 4), "R7 split read data", rd_got, exp_read(32'h10, 4));
  endtask

  task automatic t_write16;
    set_cfg(4'd2, 2'b01, 1'b1, 2'b10, 1'b0, 1'b1);
    run_xfer(1'b1, 2'b10, 32'h300, DW'(32'hCAFEBABE), -1);
    chk(nbeats == 2 && !b_burst[0] && !b_burst[1] && blen[0] == 3 && blen[1] == 3,
        "R9 write split with initial waits", blen[1], 3);
    chk(b_be[0] == 4'b1100 && b_be[1] == 4'b1100, "R6 write strobes", b_be[0], 4'b1100);
    chk(b_dout[0] == 32'hCAFE0000 && b_dout[1] == 32'hBABE0000, "R5 write lanes",
        b_dout[1], 32'hBABE0000);
  endtask

  task automatic t_byte_sub;
    set_cfg(4'd0, 2'b00, 1'b1, 2'b00, 1'b0, 1'b0);
    run_xfer(1'b1, 2'b00, 32'h203, DW'(8'h7E), -1);
    chk(nbeats == 1 && b_be[0] == 4'b0001 && b_dout[0] == 32'h0000007E,
        "R11 byte write offset 3", b_dout[0], 32'h7E);
    bem = 1'b1;
    run_xfer(1'b0, 2'b00, 32'h201, '0, -1);
    chk(b_be[0] == 4'b0100, "R11 byte read lane offset 1", b_be[0], 4'b0100);
    chk(rd_got == exp_read(32'h201, 1), "R11 byte read data", rd_got, exp_read(32'h201, 1));
  endtask

  task automatic t_ack;
    set_cfg(4'd0, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0);
    run_xfer(1'b0, 2'b10, 32'h20, '0, 5);
    chk(nbeats == 1 && blen[0] == 6, "R2 external only end", blen[0], 6);
    set_cfg(4'd10, 2'b00, 1'b1, 2'b00, 1'b0, 1'b0);
    run_xfer(1'b0, 2'b10, 32'h24, '0, 2);
    chk(nbeats == 1 && blen[0] == 3, "R3 early external ack", blen[0], 3);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_long32_read();
    t_line8_burst();
    t_srws_codes();
    t_split();
    t_write16();
    t_byte_sub();
    t_ack();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule